// File: doc/BRIEF.md
# Packet Header Field Modifier

This block sits in a transmit byte path. It overwrites chosen header bytes of each packet with a value that changes from packet to packet, so that one configured stream carries many distinct flows. Packets enter as a byte stream with valid, start-of-packet and end-of-packet markers. They leave one cycle later with the same framing. Only the bytes covered by an enabled modifier slot differ from the input.

Each slot holds a byte offset, a mode, a bit mask, a repetition count, a lower bound, an upper bound and a step. A width select sets the slot layout. In one setting there are eight slots, each 16 bits wide. In the other there are four slots, each 32 bits wide. The value of a slot stays fixed for the whole of a packet. It moves on when the end-of-packet byte is accepted, and only after the slot's repetition count of packets has used it. A start pulse brings every slot, and the shared pseudo-random generator, back to a known starting point, so a test run can be repeated exactly.

Top module: `hdr_field_mod`

## Requirements
- R1: `out_valid`, `out_sop`, `out_eop` and `out_data` repeat `in_valid`, `in_sop`, `in_eop` and the possibly patched `in_data` one clock later. While `rst` is high, all three output markers are 0.
- R2: With `cfg_wide`=0, slots 0..7 are active 16-bit fields, and only bits 15:0 of their mask, bounds and step are used. With `cfg_wide`=1, slots 0..3 are 32-bit fields and slots 4..7 have no effect on the output.
- R3: A field starts at the byte numbered by the slot's offset, where byte 0 is the start-of-packet byte. It covers 2 bytes in 16-bit mode and 4 bytes in 32-bit mode, and is written most significant byte first.
- R4: In the covered bytes, only the bits set in the slot's mask take the slot value. All other bits keep the input data.
- R5: Mode encoding is 0 = off (the packet passes unchanged), 1 = increment, 2 = decrement, 3 = random.
- R6: Increment adds the step. If the current value plus the step would exceed the upper bound, the value wraps to the lower bound instead.
- R7: Decrement subtracts the step. If the current value minus the step would fall below the lower bound, the value wraps to the upper bound instead.
- R8: A value is used for as many packets as the repetition count before it advances. A count of 0 behaves as 1.
- R9: A value advances only when an end-of-packet byte is accepted, and it is held for every byte of a packet. A one-byte packet (start and end together) also advances it.
- R10: A start pulse loads each slot with its upper bound in decrement mode and with its lower bound in every other mode. It also resets the repetition count and reloads the generator seed.
- R11: Random mode uses one 32-bit generator. Its seed is 32'h1ACE_B00C. Each accepted end-of-packet shifts it right by one bit, and when the bit shifted out is 1 it is XORed with 32'h8020_0003. When slot k advances, it takes the generator state from before that shift and rotates it left by 4k bits, keeping 16 or 32 bits to give raw value r. Let span = upper bound minus lower bound, and let f be span with all bits below its highest set bit filled with 1. Then m = r AND f. The new value is the lower bound + m when m is at most span, and the lower bound + m − span − 1 otherwise.
- R12: Where fields overlap, slots are applied from slot 0 upward, so a higher-numbered slot's masked bits take effect on top of a lower one's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Reload pulse for all slots and the generator |
| cfg_wide | input | 1 | 0: eight 16-bit slots, 1: four 32-bit slots |
| cfg_mode | input | NSLOT*2 | Per-slot mode, slot k at bits 2k+1:2k |
| cfg_offset | input | NSLOT*OFFW | Per-slot byte offset |
| cfg_mask | input | NSLOT*32 | Per-slot bit mask |
| cfg_repeat | input | NSLOT*REPW | Per-slot repetition count |
| cfg_min | input | NSLOT*32 | Per-slot lower bound |
| cfg_max | input | NSLOT*32 | Per-slot upper bound |
| cfg_step | input | NSLOT*32 | Per-slot step |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | First byte of packet |
| in_eop | input | 1 | Last byte of packet |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_sop | output | 1 | First byte of packet |
| out_eop | output | 1 | Last byte of packet |
| out_data | output | 8 | Patched output byte |

## Verification
The assertions check the following on every cycle:
- the one-cycle framing relation;
- that a byte with no masked field bit leaves the block unchanged;
- that a slot value never moves except at a start pulse or an end-of-packet;
- that each start pulse loads the correct bound;
- that every random draw lands inside the bounds.

Some behaviour is a sequence over several packets, and only the bench scenarios can show it:
- the exact wrap points of increment and decrement;
- how long the repetition count holds a value;
- the most-significant-first byte placement and mask merge against known background bytes;
- slot overlap order;
- the ignored upper slots in 32-bit mode;
- the seeded random sequence.

// File: rtl/hfm_pkg.sv
package hfm_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_INC  = 2'd1,
    MODE_DEC  = 2'd2,
    MODE_RAND = 2'd3
  } hfm_mode_e;

  localparam logic [31:0] LFSR_TAPS = 32'h8020_0003;

  // fill every bit below the highest set bit
  function automatic logic [31:0] smear(input logic [31:0] x);
    logic [31:0] y;
    y = x;
    y = y | (y >> 1);
    y = y | (y >> 2);
    y = y | (y >> 4);
    y = y | (y >> 8);
    y = y | (y >> 16);
    return y;
  endfunction

endpackage

// File: rtl/hfm_lfsr.sv
module hfm_lfsr #(
  parameter logic [31:0] SEED = 32'h1ACE_B00C
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        restart,
  input  logic        step,
  output logic [31:0] state
);
  import hfm_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      state <= SEED;
    end else if (step) begin
      state <= {1'b0, state[31:1]} ^ ({32{state[0]}} & LFSR_TAPS);
    end
  end

endmodule

// File: rtl/hfm_slot.sv
module hfm_slot #(
  parameter int REPW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            adv,
  input  logic            active,
  input  logic            wide,
  input  logic [1:0]      mode,
  input  logic [31:0]     mn,
  input  logic [31:0]     mx,
  input  logic [31:0]     stp,
  input  logic [REPW-1:0] rep,
  input  logic [31:0]     rnd,
  output logic [31:0]     value
);
  import hfm_pkg::*;

  logic [31:0]     wmask, emn, emx, estp, span, fill, m, fold, nxt;
  logic [REPW-1:0] rep_cnt;
  logic            rep_last;
  hfm_mode_e       md;

  assign md    = hfm_mode_e'(mode);
  assign wmask = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  assign emn   = mn & wmask;
  assign emx   = mx & wmask;
  assign estp  = stp & wmask;
  assign span  = emx - emn;
  assign fill  = smear(span);
  assign m     = rnd & wmask & fill;
  assign fold  = (m > span) ? (m - span - 32'd1) : m;

  assign rep_last = ({1'b0, rep_cnt} + 1'b1) >= {1'b0, rep};

  always_comb begin
    case (md)
      MODE_INC:  nxt = ((value > emx) || ((emx - value) < estp)) ? emn : value + estp;
      MODE_DEC:  nxt = ((value < emn) || ((value - emn) < estp)) ? emx : value - estp;
      MODE_RAND: nxt = emn + fold;
      default:   nxt = value;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      value   <= '0;
      rep_cnt <= '0;
    end else if (start) begin
      value   <= (md == MODE_DEC) ? emx : emn;
      rep_cnt <= '0;
    end else if (adv && active) begin
      if (rep_last) begin
        value   <= nxt;
        rep_cnt <= '0;
      end else begin
        rep_cnt <= rep_cnt + 1'b1;
      end
    end
  end

  AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (rst)
    (!start && !adv) |=> $stable(value)); // R9

  AST_START_LOAD: assert property (@(posedge clk) disable iff (rst)
    start |=> (value == ($past(md == MODE_DEC) ? $past(emx) : $past(emn)))); // R10

  AST_RAND_RANGE: assert property (@(posedge clk) disable iff (rst)
    (!start && adv && active && md == MODE_RAND && rep_last && emn <= emx)
    |=> (value >= $past(emn) && value <= $past(emx))); // R11

endmodule

// File: rtl/hfm_patch.sv
module hfm_patch #(
  parameter int NSLOT = 8,
  parameter int OFFW  = 8,
  parameter int POSW  = 14
) (
  input  logic [POSW-1:0]       pos,
  input  logic [7:0]            din,
  input  logic                  wide,
  input  logic [NSLOT-1:0]      act,
  input  logic [NSLOT*OFFW-1:0] offs,
  input  logic [NSLOT*32-1:0]   masks,
  input  logic [NSLOT*32-1:0]   vals,
  output logic [7:0]            dout,
  output logic                  hit
);
  localparam int PW = POSW + 1;

  always_comb begin
    logic [PW-1:0] p, lo, len, rel;
    logic [4:0]    sh;
    logic [7:0]    vb, mb, d;
    logic          h;
    p   = {1'b0, pos};
    len = wide ? PW'(4) : PW'(2);
    d   = din;
    h   = 1'b0;
    lo  = '0;
    rel = '0;
    sh  = '0;
    vb  = '0;
    mb  = '0;
    // ascending order: later slots override earlier ones
    for (int k = 0; k < NSLOT; k++) begin
      lo  = PW'(offs[k*OFFW +: OFFW]);
      rel = p - lo;
      if (act[k] && (p >= lo) && (rel < len)) begin
        sh = 5'((len - PW'(1) - rel) * 8);
        vb = 8'(vals[k*32 +: 32] >> sh);
        mb = 8'(masks[k*32 +: 32] >> sh);
        d  = (d & ~mb) | (vb & mb);
        h  = h | (mb != 8'h00);
      end
    end
    dout = d;
    hit  = h;
  end

endmodule

// File: rtl/hdr_field_mod.sv
module hdr_field_mod #(
  parameter int          NSLOT     = 8,
  parameter int          OFFW      = 8,
  parameter int          REPW      = 16,
  parameter int          POSW      = 14,
  parameter logic [31:0] LFSR_SEED = 32'h1ACE_B00C
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  cfg_wide,
  input  logic [NSLOT*2-1:0]    cfg_mode,
  input  logic [NSLOT*OFFW-1:0] cfg_offset,
  input  logic [NSLOT*32-1:0]   cfg_mask,
  input  logic [NSLOT*REPW-1:0] cfg_repeat,
  input  logic [NSLOT*32-1:0]   cfg_min,
  input  logic [NSLOT*32-1:0]   cfg_max,
  input  logic [NSLOT*32-1:0]   cfg_step,
  input  logic                  in_valid,
  input  logic                  in_sop,
  input  logic                  in_eop,
  input  logic [7:0]            in_data,
  output logic                  out_valid,
  output logic                  out_sop,
  output logic                  out_eop,
  output logic [7:0]            out_data
);
  localparam int NWIDE = NSLOT / 2;

  logic [POSW-1:0]     cnt, pos;
  logic                adv, hit;
  logic [31:0]         lfsr_q;
  logic [NSLOT-1:0]    act;
  logic [NSLOT*32-1:0] vals;
  logic [7:0]          patched;

  assign pos = in_sop ? '0 : cnt;
  assign adv = in_valid && in_eop;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (in_valid) begin
      cnt <= (pos == '1) ? pos : pos + 1'b1;
    end
  end

  hfm_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
    .clk     (clk),
    .rst     (rst),
    .restart (start),
    .step    (adv),
    .state   (lfsr_q)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam int ROT = (4 * g) % 32;
    logic [31:0] rnd;
    assign rnd    = 32'({lfsr_q, lfsr_q} >> (32 - ROT));
    assign act[g] = (cfg_mode[g*2 +: 2] != 2'd0) && (!cfg_wide || (g < NWIDE));

    hfm_slot #(.REPW(REPW)) u_slot (
      .clk    (clk),
      .rst    (rst),
      .start  (start),
      .adv    (adv),
      .active (act[g]),
      .wide   (cfg_wide),
      .mode   (cfg_mode[g*2 +: 2]),
      .mn     (cfg_min[g*32 +: 32]),
      .mx     (cfg_max[g*32 +: 32]),
      .stp    (cfg_step[g*32 +: 32]),
      .rep    (cfg_repeat[g*REPW +: REPW]),
      .rnd    (rnd),
      .value  (vals[g*32 +: 32])
    );
  end

  hfm_patch #(.NSLOT(NSLOT), .OFFW(OFFW), .POSW(POSW)) u_patch (
    .pos   (pos),
    .din   (in_data),
    .wide  (cfg_wide),
    .act   (act),
    .offs  (cfg_offset),
    .masks (cfg_mask),
    .vals  (vals),
    .dout  (patched),
    .hit   (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_sop   <= in_valid && in_sop;
      out_eop   <= in_valid && in_eop;
      out_data  <= patched;
    end
  end

  AST_FRAME_VALID: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1

  AST_FRAME_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R1

  AST_FRAME_MARKS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_sop == $past(in_sop) && out_eop == $past(in_eop))); // R1

  AST_UNHIT_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !hit) |=> (out_data == $past(in_data))); // R4

endmodule

// File: tb/hdr_field_mod_bench.sv
`timescale 1ns/1ps
module hdr_field_mod_bench;
  localparam int NSLOT = 8;
  localparam int OFFW  = 8;
  localparam int REPW  = 16;
  localparam logic [31:0] SEED = 32'h1ACE_B00C;
  localparam logic [31:0] TAPS = 32'h8020_0003;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic cfg_wide = 1'b0;
  logic [NSLOT*2-1:0]    cfg_mode = '0;
  logic [NSLOT*OFFW-1:0] cfg_offset = '0;
  logic [NSLOT*32-1:0]   cfg_mask = '0;
  logic [NSLOT*REPW-1:0] cfg_repeat = '0;
  logic [NSLOT*32-1:0]   cfg_min = '0, cfg_max = '0, cfg_step = '0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0] in_data = '0;
  logic out_valid, out_sop, out_eop;
  logic [7:0] out_data;

  always #5 clk = ~clk;

  hdr_field_mod u_hdr_field_mod (
    .clk(clk), .rst(rst), .start(start), .cfg_wide(cfg_wide),
    .cfg_mode(cfg_mode), .cfg_offset(cfg_offset), .cfg_mask(cfg_mask),
    .cfg_repeat(cfg_repeat), .cfg_min(cfg_min), .cfg_max(cfg_max),
    .cfg_step(cfg_step), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_data(in_data), .out_valid(out_valid),
    .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] cap [0:63];
  logic       cap_sop [0:63];
  logic       cap_eop [0:63];
  int cap_n = 0;

  always @(negedge clk) begin
    if (out_valid && cap_n < 64) begin
      cap[cap_n]     = out_data;
      cap_sop[cap_n] = out_sop;
      cap_eop[cap_n] = out_eop;
      cap_n          = cap_n + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_cfg();
    cfg_mode = '0; cfg_offset = '0; cfg_mask = '0; cfg_repeat = '0;
    cfg_min = '0; cfg_max = '0; cfg_step = '0; cfg_wide = 1'b0;
  endtask

  task automatic set_slot(input int k, input logic [1:0] md, input logic [7:0] off,
                          input logic [31:0] msk, input logic [15:0] rp,
                          input logic [31:0] mn, input logic [31:0] mx, input logic [31:0] st);
    cfg_mode[k*2 +: 2]         = md;
    cfg_offset[k*OFFW +: OFFW] = off;
    cfg_mask[k*32 +: 32]       = msk;
    cfg_repeat[k*REPW +: REPW] = rp;
    cfg_min[k*32 +: 32]        = mn;
    cfg_max[k*32 +: 32]        = mx;
    cfg_step[k*32 +: 32]       = st;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic send_pkt(input int len);
    cap_n = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sop   = (i == 0);
      in_eop   = (i == len - 1);
      in_data  = 8'hC0 + 8'(i);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] field(input int off, input int nb);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < nb; i++) r = (r << 8) | 32'(cap[off + i]);
    return r;
  endfunction

  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    return {1'b0, s[31:1]} ^ (s[0] ? TAPS : 32'h0);
  endfunction

  function automatic logic [31:0] fold(input logic [31:0] r, input logic [31:0] span);
    logic [31:0] f, m;
    f = span;
    for (int i = 0; i < 5; i++) f = f | (f >> (1 << i));
    m = r & f;
    return (m > span) ? (m - span - 32'd1) : m;
  endfunction

  typedef struct packed {
    logic        wide;
    logic [1:0]  mode;
    logic [7:0]  off;
    logic [31:0] mask;
    logic [15:0] rep;
    logic [31:0] mn, mx, st;
    logic [31:0] e0, e1, e2, e3;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VEC [NVEC] = '{
    // R6 increment wrap
    '{1'b0, 2'd1, 8'd2, 32'h0000FFFF, 16'd1, 32'h10, 32'h12, 32'h1, 32'h10, 32'h11, 32'h12, 32'h10},
    // R7 decrement wrap, start loads max
    '{1'b0, 2'd2, 8'd0, 32'h0000FFFF, 16'd1, 32'h100, 32'h105, 32'h2, 32'h105, 32'h103, 32'h101, 32'h105},
    // R8 repetition 2
    '{1'b0, 2'd1, 8'd1, 32'h0000FFFF, 16'd2, 32'h5, 32'h20, 32'h3, 32'h5, 32'h5, 32'h8, 32'h8},
    // R2 32-bit field
    '{1'b1, 2'd1, 8'd3, 32'hFFFFFFFF, 16'd1, 32'hFFFFFFFD, 32'hFFFFFFFF, 32'h1, 32'hFFFFFFFD, 32'hFFFFFFFE, 32'hFFFFFFFF, 32'hFFFFFFFD},
    // R4 mask merge against background C4 C5
    '{1'b0, 2'd1, 8'd4, 32'h000000F0, 16'd1, 32'h1234, 32'h1240, 32'h4, 32'hC435, 32'hC435, 32'hC435, 32'hC445},
    // R7 R8 decrement, 32-bit, repetition 3
    '{1'b1, 2'd2, 8'd0, 32'hFFFFFFFF, 16'd3, 32'h10000000, 32'h10000020, 32'h10, 32'h10000020, 32'h10000020, 32'h10000020, 32'h10000010},
    // R5 off mode passes data
    '{1'b0, 2'd0, 8'd2, 32'h0000FFFF, 16'd1, 32'h0, 32'h0, 32'h0, 32'hC2C3, 32'hC2C3, 32'hC2C3, 32'hC2C3}
  };

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] s, e0, e1;
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", 32'(out_valid), 32'h0);
    chk("R1 reset out_sop", 32'(out_sop), 32'h0);
    chk("R1 reset out_eop", 32'(out_eop), 32'h0);
    rst = 1'b0;
    @(negedge clk);

    // vector table walk (R3 placement in every row)
    for (int v = 0; v < NVEC; v++) begin
      int nb;
      logic [31:0] exp;
      clear_cfg();
      cfg_wide = VEC[v].wide;
      nb = VEC[v].wide ? 4 : 2;
      set_slot(0, VEC[v].mode, VEC[v].off, VEC[v].mask, VEC[v].rep, VEC[v].mn, VEC[v].mx, VEC[v].st);
      pulse_start();
      for (int p = 0; p < 4; p++) begin
        exp = (p == 0) ? VEC[v].e0 : (p == 1) ? VEC[v].e1 : (p == 2) ? VEC[v].e2 : VEC[v].e3;
        send_pkt(8);
        chk($sformatf("R3 vec%0d pkt%0d field", v, p), field(VEC[v].off, nb), exp);
        if (v == 0 && p == 0) begin
          chk("R1 byte count", 32'(cap_n), 32'd8);
          chk("R1 sop on first", 32'(cap_sop[0]), 32'h1);
          chk("R1 eop on last", 32'(cap_eop[7]), 32'h1);
          chk("R1 untouched byte", 32'(cap[0]), 32'hC0);
        end
      end
    end

    // R11 random: power-of-two span on slot 0, non power-of-two on slot 1
    clear_cfg();
    set_slot(0, 2'd3, 8'd0, 32'hFFFF, 16'd1, 32'h100, 32'h1FF, 32'h0);
    set_slot(1, 2'd3, 8'd4, 32'hFFFF, 16'd1, 32'd10, 32'd15, 32'h0);
    pulse_start();
    send_pkt(8);
    chk("R11 first after start slot0", field(0, 2), 32'h100);
    chk("R11 first after start slot1", field(4, 2), 32'd10);
    s = SEED;
    for (int p = 0; p < 4; p++) begin
      e0 = 32'h100 + fold(s & 32'hFFFF, 32'hFF);
      e1 = 32'd10 + fold({s[27:0], s[31:28]} & 32'hFFFF, 32'd5);
      s = lfsr_next(s);
      send_pkt(8);
      chk($sformatf("R11 slot0 draw %0d", p), field(0, 2), e0);
      chk($sformatf("R11 slot1 draw %0d", p), field(4, 2), e1);
    end

    // R12 overlap: slot1 overrides slot0 on shared byte
    clear_cfg();
    set_slot(0, 2'd1, 8'd0, 32'hFFFF, 16'd1, 32'h1111, 32'h1111, 32'h0);
    set_slot(1, 2'd1, 8'd1, 32'hFFFF, 16'd1, 32'h2222, 32'h2222, 32'h0);
    pulse_start();
    send_pkt(8);
    chk("R12 overlap order", field(0, 3), 32'h112222);

    // R2 wide mode ignores slot 4
    clear_cfg();
    cfg_wide = 1'b1;
    set_slot(4, 2'd1, 8'd0, 32'hFFFFFFFF, 16'd1, 32'hAAAAAAAA, 32'hAAAAAAAA, 32'h0);
    pulse_start();
    send_pkt(8);
    chk("R2 slot4 ignored in wide", field(0, 4), 32'hC0C1C2C3);

    // R2 narrow mode uses low 16 bits only
    clear_cfg();
    set_slot(0, 2'd1, 8'd0, 32'hFFFFFFFF, 16'd1, 32'hABCD1234, 32'hABCD1240, 32'h4);
    pulse_start();
    send_pkt(8);
    chk("R2 narrow low half", field(0, 3), 32'h1234C2);
    send_pkt(8);
    chk("R2 narrow advance", field(0, 3), 32'h1238C2);

    // R8 repeat 0 as 1, R9 one-byte packet advances, R10 restart
    clear_cfg();
    set_slot(0, 2'd1, 8'd0, 32'hFFFF, 16'd0, 32'h0, 32'h9, 32'h1);
    pulse_start();
    send_pkt(8);
    chk("R8 repeat zero first", field(0, 2), 32'h0);
    send_pkt(1);
    send_pkt(8);
    chk("R9 one-byte packet advanced", field(0, 2), 32'h2);
    pulse_start();
    send_pkt(8);
    chk("R10 restart to min", field(0, 2), 32'h0);

    // R9 value held across a packet
    clear_cfg();
    set_slot(0, 2'd1, 8'd0, 32'hFFFF, 16'd1, 32'h7, 32'h9, 32'h1);
    set_slot(1, 2'd1, 8'd6, 32'hFFFF, 16'd1, 32'h7, 32'h9, 32'h1);
    pulse_start();
    send_pkt(8);
    chk("R9 head of packet", field(0, 2), 32'h7);
    chk("R9 tail of packet", field(6, 2), 32'h7);
    send_pkt(8);
    chk("R9 next packet head", field(0, 2), 32'h8);
    chk("R9 next packet tail", field(6, 2), 32'h8);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule